// File: doc/BRIEF.md
# Serial Payload Bit Error Rate Test Engine

This block sits on a serial payload path and runs bit error rate tests on it. On the transmit side it can replace the system payload with a test pattern. On the receive side it checks incoming payload bits against the same pattern. The pattern is either a pseudo-random sequence or a user word of 1 to 32 bits that repeats. The pseudo-random sequence comes from a shift register whose length (1 to 32) and feedback tap mask are set by configuration, so periods up to 2^32-1 are possible.

Test mode does not change the timing seen by the system side. The transmit and receive bit strobes keep running at the line rate. While the engine is enabled, transmit system data is dropped and received line data is still passed to the system side. The receive checker locks to the incoming stream on its own. It keeps saturating counts of compared bits and of bit errors, and drops lock when errors become too dense. A single-pulse request flips exactly one transmitted bit, which lets the far end's error counting be tested.

Configuration (mode, length, taps, pattern word) is expected to stay unchanged while the engine is enabled. Clearing the enable reloads the transmit seed and clears the checker and both counters.

Top module: `bert_engine`

## Requirements
- R1: While cfg_en is 0, tx_line_data equals tx_sys_data in the same cycle, sync is 0, and err_count and bit_count read 0 one cycle after cfg_en falls.
- R2: While cfg_en is 1, tx_line_data carries the next pattern bit in every cycle where tx_bit_en is 1. The pattern advances only on those cycles and tx_sys_data has no effect on the output.
- R3: rx_sys_data equals rx_line_data in every cycle, whether cfg_en is 0 or 1.
- R4: In PRBS mode (cfg_mode = 0), with length L = cfg_len + 1, each output bit is the XOR of the L-bit state ANDed with cfg_taps. The state then shifts left by one, with the output bit entering bit 0. The state is loaded with all ones while cfg_en is 0.
- R5: In PRBS mode, if shifting the state would leave all L bits at zero, the output bit (and so the new bit 0) is forced to 1. The state is therefore never all zeros.
- R6: In repeat mode (cfg_mode = 1), the low L bits of cfg_pat are sent from bit L-1 down to bit 0, and this repeats without a break.
- R7: After enable or after losing sync, the checker takes L received bits to fill its state, then needs 32 consecutive correctly predicted bits. sync reads 1 in the cycle after the 32nd of those bits.
- R8: Once in sync, received bits are grouped into blocks of 64, starting with the first in-sync bit. The 6th error inside one block clears sync after that bit. Five errors in a block leave sync set.
- R9: bit_count advances once per received bit while sync is 1, and err_count once per mismatching bit while sync is 1. Both hold when they reach their all-ones value.
- R10: A pulse on err_inject inverts exactly one transmitted bit: the bit of that cycle if tx_bit_en is 1, otherwise the next bit sent. The pattern that follows is unaffected.
- R11: While in sync, the checker predicts from its own sequence and not from the received bits, so one corrupted received bit adds exactly one to err_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Engine enable |
| cfg_mode | input | 1 | 0 = PRBS, 1 = repeating word |
| cfg_len | input | 5 | Pattern length minus one |
| cfg_taps | input | 32 | PRBS feedback tap mask over the state bits |
| cfg_pat | input | 32 | Repeating word, low L bits used |
| err_inject | input | 1 | Single-bit error insertion request |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_sys_data | input | 1 | Transmit payload from the system side |
| tx_line_data | output | 1 | Transmit payload toward the line |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_line_data | input | 1 | Receive payload from the line |
| rx_sys_data | output | 1 | Receive payload toward the system side |
| sync | output | 1 | Checker locked to the pattern |
| err_count | output | CNT_W | Saturating in-sync error count |
| bit_count | output | CNT_W | Saturating in-sync bit count |

## Verification
The hardest state to reach from the ports is a saturated error counter while sync is still held, because any error density high enough to fill the counter quickly also breaks lock. The bench builds the engine with a narrow counter width. It tracks the 64-bit block position from the moment sync is acquired and corrupts exactly five received bits at the start of every block, for long enough to pass the counter limit. Loss of sync is reached with a sixth error in a block that is also aligned that way. The zero-state forcing is reached directly with an empty tap mask, which drains the state within L bits.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int PAT_MAX = 32;
    localparam int LEN_W   = $clog2(PAT_MAX);

    typedef enum logic {
        PAT_PRBS   = 1'b0,
        PAT_REPEAT = 1'b1
    } pat_mode_e;

    // Mask of the active low L bits, L = lm1 + 1
    function automatic logic [PAT_MAX-1:0] len_mask(input logic [LEN_W-1:0] lm1);
        logic [PAT_MAX-1:0] ones;
        ones = '1;
        return ones >> (LEN_W'(PAT_MAX-1) - lm1);
    endfunction

    // Bit produced from the current state in either mode
    function automatic logic next_bit(input logic [PAT_MAX-1:0] state,
                                      input logic [PAT_MAX-1:0] taps,
                                      input logic [LEN_W-1:0]   lm1,
                                      input pat_mode_e          mode);
        logic [PAT_MAX-1:0] m;
        logic               fb;
        m = len_mask(lm1);
        if (mode == PAT_REPEAT) begin
            fb = state[lm1];
        end else begin
            fb = ^(state & taps & m);
            if (((state << 1) & m) == '0) fb = 1'b1;
        end
        return fb;
    endfunction

    function automatic logic [PAT_MAX-1:0] shift_in(input logic [PAT_MAX-1:0] state,
                                                    input logic               b,
                                                    input logic [LEN_W-1:0]   lm1);
        return ((state << 1) | {{(PAT_MAX-1){1'b0}}, b}) & len_mask(lm1);
    endfunction

endpackage

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               step,
    input  pat_mode_e          mode,
    input  logic [LEN_W-1:0]   lm1,
    input  logic [PAT_MAX-1:0] taps,
    input  logic [PAT_MAX-1:0] seed,
    output logic               bit_o
);

    typedef struct packed {
        logic [PAT_MAX-1:0] state;
    } gen_s;

    gen_s gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        bit_o = next_bit(gen_q.state, taps, lm1, mode);
        if (!en) begin
            gen_d.state = (mode == PAT_REPEAT) ? (seed & len_mask(lm1)) : len_mask(lm1);
        end else if (step) begin
            gen_d.state = shift_in(gen_q.state, bit_o, lm1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '{state: '1};
        else        gen_q <= gen_d;
    end

    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PAT_PRBS && $past(en && step && mode == PAT_PRBS) && $stable(lm1))
        |-> ((gen_q.state & len_mask(lm1)) != '0)) else $error("zero state"); // R5

endmodule

// File: rtl/bert_checker.sv
module bert_checker
    import bert_pkg::*;
#(
    parameter int SYNC_RUN  = 32,
    parameter int WIN_BITS  = 64,
    parameter int LOSS_ERRS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               step,
    input  logic               rx_bit,
    input  pat_mode_e          mode,
    input  logic [LEN_W-1:0]   lm1,
    input  logic [PAT_MAX-1:0] taps,
    output logic               sync_o,
    output logic               bit_inc,
    output logic               err_inc
);

    localparam int RUN_W = $clog2(SYNC_RUN + 1);
    localparam int POS_W = $clog2(WIN_BITS);
    localparam int BE_W  = $clog2(LOSS_ERRS + 1);

    typedef struct packed {
        logic [PAT_MAX-1:0] sreg;
        logic [LEN_W:0]     fill;
        logic [RUN_W-1:0]   run;
        logic               sync;
        logic [POS_W-1:0]   pos;
        logic [BE_W-1:0]    blk;
    } chk_s;

    chk_s chk_d, chk_q;
    logic exp_b, miss;

    always_comb begin
        chk_d   = chk_q;
        bit_inc = 1'b0;
        err_inc = 1'b0;
        exp_b   = next_bit(chk_q.sreg, taps, lm1, mode);
        miss    = rx_bit ^ exp_b;
        if (!en) begin
            chk_d = '0;
        end else if (step) begin
            if (!chk_q.sync) begin
                chk_d.sreg = shift_in(chk_q.sreg, rx_bit, lm1);
                if (chk_q.fill <= {1'b0, lm1}) begin
                    chk_d.fill = chk_q.fill + 1'b1;
                    chk_d.run  = '0;
                end else if (miss) begin
                    chk_d.run = '0;
                end else if (chk_q.run == RUN_W'(SYNC_RUN - 1)) begin
                    chk_d.sync = 1'b1;
                    chk_d.run  = '0;
                    chk_d.pos  = '0;
                    chk_d.blk  = '0;
                end else begin
                    chk_d.run = chk_q.run + 1'b1;
                end
            end else begin
                chk_d.sreg = shift_in(chk_q.sreg, exp_b, lm1);
                bit_inc    = 1'b1;
                err_inc    = miss;
                if (miss && chk_q.blk == BE_W'(LOSS_ERRS - 1)) begin
                    chk_d.sync = 1'b0;
                    chk_d.fill = '0;
                    chk_d.run  = '0;
                end else if (chk_q.pos == POS_W'(WIN_BITS - 1)) begin
                    chk_d.pos = '0;
                    chk_d.blk = '0;
                end else begin
                    chk_d.pos = chk_q.pos + 1'b1;
                    chk_d.blk = chk_q.blk + BE_W'(miss);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign sync_o = chk_q.sync;

    AST_SYNC_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_q.sync) |-> $past(en && step)) else $error("sync rose without bit"); // R7
    AST_LOSS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(chk_q.sync) && $past(en)) |-> $past(step && miss)) else $error("sync lost without error"); // R8
    AST_BLK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q.sync |-> (chk_q.blk < BE_W'(LOSS_ERRS))) else $error("block errors over limit"); // R8

endmodule

// File: rtl/bert_satcnt.sv
module bert_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                       cnt_d.cnt = '0;
        else if (inc && ~&cnt_q.cnt)   cnt_d.cnt = cnt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;

    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q.cnt && !clr) |=> &cnt_q.cnt) else $error("counter wrapped"); // R9
    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q.cnt == $past(cnt_q.cnt) || cnt_q.cnt == $past(cnt_q.cnt) + 1'b1))
        else $error("counter jumped"); // R9

endmodule

// File: rtl/bert_engine.sv
module bert_engine
    import bert_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_RUN  = 32,
    parameter int WIN_BITS  = 64,
    parameter int LOSS_ERRS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_mode,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [PAT_MAX-1:0] cfg_taps,
    input  logic [PAT_MAX-1:0] cfg_pat,
    input  logic               err_inject,
    input  logic               tx_bit_en,
    input  logic               tx_sys_data,
    output logic               tx_line_data,
    input  logic               rx_bit_en,
    input  logic               rx_line_data,
    output logic               rx_sys_data,
    output logic               sync,
    output logic [CNT_W-1:0]   err_count,
    output logic [CNT_W-1:0]   bit_count
);

    localparam int NCNT = 2;

    typedef struct packed {
        logic inj;
    } top_s;

    top_s      top_d, top_q;
    pat_mode_e mode;
    logic      gen_bit, flip, bit_inc, err_inc;
    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_val [NCNT];

    assign mode = pat_mode_e'(cfg_mode);

    bert_patgen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_en),
        .step  (tx_bit_en),
        .mode  (mode),
        .lm1   (cfg_len),
        .taps  (cfg_taps),
        .seed  (cfg_pat),
        .bit_o (gen_bit)
    );

    bert_checker #(
        .SYNC_RUN  (SYNC_RUN),
        .WIN_BITS  (WIN_BITS),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .step    (rx_bit_en),
        .rx_bit  (rx_line_data),
        .mode    (mode),
        .lm1     (cfg_len),
        .taps    (cfg_taps),
        .sync_o  (sync),
        .bit_inc (bit_inc),
        .err_inc (err_inc)
    );

    assign cnt_inc = {err_inc, bit_inc};

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        bert_satcnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (~cfg_en),
            .inc   (cnt_inc[gi]),
            .count (cnt_val[gi])
        );
    end

    assign bit_count = cnt_val[0];
    assign err_count = cnt_val[1];

    always_comb begin
        top_d        = top_q;
        flip         = cfg_en & tx_bit_en & (top_q.inj | err_inject);
        top_d.inj    = cfg_en & (top_q.inj | err_inject) & ~tx_bit_en;
        tx_line_data = cfg_en ? (gen_bit ^ flip) : tx_sys_data;
        rx_sys_data  = rx_line_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    AST_INJECT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> !top_q.inj) else $error("inject stayed pending"); // R10
    AST_BITS_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && $past(cfg_en) && !$past(sync)) |-> (bit_count == $past(bit_count)))
        else $error("bits counted out of sync"); // R9

endmodule

// File: tb/tb_bert_engine.sv
module tb_bert_engine;

    localparam int CW     = 10;
    localparam int SATMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_mode = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic [31:0] cfg_taps = '0, cfg_pat = '0;
    logic err_inject = 1'b0, tx_bit_en = 1'b0, tx_sys_data = 1'b0;
    logic rx_bit_en = 1'b0, rx_line_data = 1'b0;
    logic tx_line_data, rx_sys_data, sync;
    logic [CW-1:0] err_count, bit_count;

    always #2.5 clk = ~clk;

    bert_engine #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_len(cfg_len), .cfg_taps(cfg_taps), .cfg_pat(cfg_pat),
        .err_inject(err_inject), .tx_bit_en(tx_bit_en), .tx_sys_data(tx_sys_data),
        .tx_line_data(tx_line_data), .rx_bit_en(rx_bit_en), .rx_line_data(rx_line_data),
        .rx_sys_data(rx_sys_data), .sync(sync), .err_count(err_count), .bit_count(bit_count)
    );

    int checks = 0, failures = 0;

    // bench model state
    int          L;
    bit          bmode;
    logic [31:0] btaps, bpat, mtx, mrx;
    int          ktx, krx;
    bit          pend, m_sync, last_tx;
    int          m_since, m_pos, m_blk, m_bits, m_errs;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lmask(input int len);
        return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
    endfunction

    function automatic bit ref_prbs(input logic [31:0] st, input logic [31:0] tp, input int len);
        bit p = 1'b0;
        for (int i = 0; i < len; i++) p ^= st[i] & tp[i];
        if (((st << 1) & lmask(len)) == 0) p = 1'b1;
        return p;
    endfunction

    function automatic logic [31:0] ref_adv(input logic [31:0] st, input bit b, input int len);
        return ((st << 1) | {31'd0, b}) & lmask(len);
    endfunction

    function automatic bit ref_rep(input logic [31:0] pt, input int len, input int k);
        return pt[len - 1 - (k % len)];
    endfunction

    function automatic bit tx_exp_bit();
        return bmode ? ref_rep(bpat, L, ktx) : ref_prbs(mtx, btaps, L);
    endfunction

    function automatic bit rx_exp_bit();
        return bmode ? ref_rep(bpat, L, krx) : ref_prbs(mrx, btaps, L);
    endfunction

    task automatic configure(input bit md, input int len, input logic [31:0] tp, input logic [31:0] pt);
        @(negedge clk);
        cfg_en = 1'b0; tx_bit_en = 1'b0; rx_bit_en = 1'b0; err_inject = 1'b0;
        cfg_mode = md; cfg_len = 5'(len - 1); cfg_taps = tp; cfg_pat = pt;
        @(negedge clk);
        cfg_en = 1'b1;
        bmode = md; L = len; btaps = tp; bpat = pt;
        mtx = lmask(len); mrx = lmask(len); ktx = 0; krx = 0; pend = 1'b0;
        m_sync = 1'b0; m_since = 0; m_pos = 0; m_blk = 0; m_bits = 0; m_errs = 0;
    endtask

    task automatic step(input bit txen, input bit rxen, input bit rxflip, input bit inj);
        bit rxb, sysb, txe;
        @(negedge clk);
        check("R7 R8 sync", sync, m_sync);
        rxb  = rx_exp_bit();
        sysb = 1'($urandom);
        tx_bit_en = txen; rx_bit_en = rxen; rx_line_data = rxb ^ rxflip;
        err_inject = inj; tx_sys_data = sysb;
        #1;
        check("R3 rx passthrough", rx_sys_data, rx_line_data);
        if (cfg_en) begin
            if (txen) begin
                txe = tx_exp_bit() ^ (pend | inj);
                last_tx = tx_line_data;
                check("R2 R4 R6 tx pattern", tx_line_data, txe);
                if (bmode) ktx++;
                else mtx = ref_adv(mtx, ref_prbs(mtx, btaps, L), L);
                pend = 1'b0;
            end else begin
                pend |= inj;
            end
            if (rxen) begin
                if (bmode) krx++;
                else mrx = ref_adv(mrx, rxb, L);
                if (!m_sync) begin
                    m_since++;
                    if (m_since == L + 32) begin m_sync = 1'b1; m_pos = 0; m_blk = 0; end
                end else begin
                    if (m_bits < SATMAX) m_bits++;
                    if (rxflip) begin
                        if (m_errs < SATMAX) m_errs++;
                        m_blk++;
                    end
                    if (m_blk == 6) begin m_sync = 1'b0; m_since = 0; end
                    else if (m_pos == 63) begin m_pos = 0; m_blk = 0; end
                    else m_pos++;
                end
            end
        end else begin
            check("R1 tx passthrough", tx_line_data, sysb);
        end
    endtask

    task automatic sample_counts(input string tag);
        @(negedge clk);
        tx_bit_en = 1'b0; rx_bit_en = 1'b0; err_inject = 1'b0;
        check({tag, " bit_count"}, 64'(bit_count), 64'(m_bits));
        check({tag, " err_count"}, 64'(err_count), 64'(m_errs));
        check({tag, " sync"}, sync, m_sync);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit raw;
        int unsigned sd;
        sd = $urandom(32'h00C0FFEE);
        L = 1; bmode = 0; btaps = 0; bpat = 0; mtx = 0; mrx = 0; ktx = 0; krx = 0;
        pend = 0; m_sync = 0; m_since = 0; m_pos = 0; m_blk = 0; m_bits = 0; m_errs = 0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // reset state and disabled pass-through (R1, R3)
        sample_counts("R1 reset");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b0);

        // PRBS, 7 bits, random strobe gaps (R2 R4 R7 R9)
        configure(1'b0, 7, 32'h0000_0060, 32'h0);
        for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, ($urandom % 4) != 0, 1'b0, 1'b0);
        sample_counts("R9 clean run");

        // one corrupted received bit while in sync (R11)
        step(1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        sample_counts("R11 single error");

        // five errors in an aligned block keep sync, six drop it (R8)
        while (m_pos != 0) step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) step(1'b1, 1'b1, i < 5, 1'b0);
        sample_counts("R8 five errors");
        check("R8 sync kept", sync, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
        sample_counts("R8 six errors");
        check("R8 sync lost", sync, 1'b0);
        // reacquire (R7)
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 reacquired", m_sync, 1'b1);

        // error insertion on a gap and on a bit (R10)
        raw = tx_exp_bit();
        step(1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 pending flip", last_tx, !raw);
        raw = tx_exp_bit();
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 next bit clean", last_tx, raw);
        raw = tx_exp_bit();
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 same cycle flip", last_tx, !raw);
        raw = tx_exp_bit();
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 after flip clean", last_tx, raw);

        // disable clears checker and counters (R1)
        @(negedge clk);
        cfg_en = 1'b0; tx_bit_en = 1'b0; rx_bit_en = 1'b0;
        m_sync = 0; m_bits = 0; m_errs = 0;
        sample_counts("R1 disabled");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b0);

        // zero-state forcing with an empty tap mask (R5)
        configure(1'b0, 4, 32'h0, 32'h0);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            check("R5 forced one", last_tx, 8'b0001_0001 >> (7 - i) & 1);
        end
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, 1'b0);

        // repeating word, 5 bits (R6)
        configure(1'b1, 5, 32'h0, 32'h0000_0016);
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            check("R6 word order", last_tx, 5'b10110 >> (4 - (i % 5)) & 1);
        end
        for (int i = 0; i < 80; i++) step(($urandom % 3) != 0, 1'b1, 1'b0, 1'b0);
        // full 32-bit word and single-bit word (R6 R7)
        configure(1'b1, 32, 32'h0, 32'hA5C3_1E77);
        for (int i = 0; i < 150; i++) step(($urandom % 4) != 0, ($urandom % 4) != 0, 1'b0, 1'b0);
        configure(1'b1, 1, 32'h0, 32'h0000_0001);
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        sample_counts("R6 R7 short word");

        // constrained random PRBS lengths and taps (R4 R7)
        for (int r = 0; r < 6; r++) begin
            configure(1'b0, 1 + int'($urandom % 32), $urandom, 32'h0);
            for (int i = 0; i < 200; i++) step(($urandom % 4) != 0, ($urandom % 4) != 0, 1'b0, 1'b0);
            check("R7 random sync", sync, 1'b1);
        end

        // counter saturation while sync is held (R9)
        configure(1'b0, 23, 32'h0042_0000, 32'h0);
        while (!m_sync) step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int b = 0; b < 210; b++)
            for (int i = 0; i < 64; i++) step(1'b1, 1'b1, m_pos < 5, 1'b0);
        sample_counts("R9 saturation");
        check("R9 err at max", 64'(err_count), 64'(SATMAX));
        check("R9 bits at max", 64'(bit_count), 64'(SATMAX));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule